// File: doc/BRIEF.md
# Partitioned Lane Arithmetic, Compare and Boolean Unit

This unit works on a 64-bit word that it treats as independent fixed-point lanes. It adds or subtracts lane by lane, either four 16-bit lanes or two 32-bit lanes. Carries and borrows never leave their own lane. A narrow form works only on the low 32 bits: either two 16-bit lanes or one 32-bit lane. In the narrow form the upper half of the result is forced to zero.

Signed lane compares build a small bitmask for an integer destination. The mask comes out on its own port and also appears, zero-extended, on the result bus. A 4-bit truth-table code selects any of the sixteen two-input Boolean functions and applies it to every bit. This covers clear, set, either source passed through or inverted, AND, OR, XOR and their inverses, and the forms with one input inverted.

An operation is presented with `in_valid` high. Its outputs are registered and appear one clock later. They hold between operations.

Top module: `simd_alu`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid`, `result` and `cmp_mask` become zero.
- R2: `out_valid` equals `in_valid` of the previous cycle. `result` and `cmp_mask` change only in the cycle after `in_valid` was high; otherwise they hold.
- R3: With `opcode`=0 (add) and `lane32`=0, each 16-bit lane of `result` is the sum of the matching lanes of `op_a` and `op_b` modulo 2^16. No carry enters the next lane.
- R4: With `lane32`=1, add and subtract use two 32-bit lanes, bits 31:0 and 63:32. Carries pass from bit 15 to bit 16 inside a lane but not from bit 31 to bit 32.
- R5: With `opcode`=1 (subtract), each lane is `op_a` minus `op_b` modulo the lane width, with no borrow across lanes.
- R6: With `narrow`=1, add, subtract and Boolean operations use only bits 31:0 of the operands. Bits 63:32 of `result` are zero.
- R7: Opcodes 2, 3, 4 and 5 are signed compares for greater-than, less-or-equal, not-equal and equal, in that order. Mask bit i holds the result for lane i, with lane 0 in the least-significant bits. With `lane32`=1 only bits 1:0 can be set. `narrow` has no effect on compares. For every non-compare opcode `cmp_mask` is zero.
- R8: For a compare, `result` equals the mask zero-extended to 64 bits.
- R9: With `opcode`=6, each bit of `result` is `lfunc[{a_bit, b_bit}]`. For example, 4'b1000 is AND, 4'b1110 is OR, 4'b0110 is XOR, 4'b1100 passes `op_a` and 4'b1010 passes `op_b`.
- R10: Opcode 7 is reserved. It produces a zero `result` and a zero `cmp_mask`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| op_a | input | 64 | First operand |
| op_b | input | 64 | Second operand |
| opcode | input | 3 | 0 add, 1 sub, 2 gt, 3 le, 4 ne, 5 eq, 6 Boolean, 7 reserved |
| lane32 | input | 1 | 0: 16-bit lanes, 1: 32-bit lanes |
| narrow | input | 1 | 1: operate on the low 32 bits only |
| lfunc | input | 4 | Truth-table code for the Boolean operation |
| out_valid | output | 1 | Registered result valid |
| result | output | 64 | Registered lane result |
| cmp_mask | output | 4 | Registered per-lane compare mask |

## Verification
The hardest case to produce from the ports is a carry that would cross a lane edge only when the lane size differs. The same operand pair has to produce different words in 16-bit and 32-bit mode. The stimulus therefore sends all-ones lanes plus one, and zero minus one, in both lane sizes. It then adds random operands checked against a lane-by-lane model. Signed compares use the 0x8000/0x7FFF pair, where an unsigned compare would give the opposite answer.

// File: rtl/simd_pkg.sv
package simd_pkg;
  typedef enum logic [2:0] {
    OP_ADD   = 3'd0,
    OP_SUB   = 3'd1,
    OP_CGT   = 3'd2,
    OP_CLE   = 3'd3,
    OP_CNE   = 3'd4,
    OP_CEQ   = 3'd5,
    OP_LOGIC = 3'd6,
    OP_RSVD  = 3'd7
  } simd_op_e;

  typedef enum logic [1:0] {
    CMP_GT = 2'd0,
    CMP_LE = 2'd1,
    CMP_NE = 2'd2,
    CMP_EQ = 2'd3
  } cmp_kind_e;
endpackage

// File: rtl/lane_addsub.sv
module lane_addsub #(
  parameter int DATA_W = 64,
  parameter int SEG_W  = 16
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              sub,
  input  logic              wide,
  output logic [DATA_W-1:0] sum
);
  localparam int NSEG = DATA_W / SEG_W;

  logic [DATA_W-1:0] b_eff;
  logic [NSEG-1:0]   cout;
  logic [NSEG-1:0]   cin;

  assign b_eff = sub ? ~b : b;

  for (genvar k = 0; k < NSEG; k++) begin : g_seg
    logic [SEG_W:0] t;
    if (k % 2 == 1) begin : g_odd
      // upper half of a wide lane takes the carry from its partner segment
      assign cin[k] = wide ? cout[k-1] : sub;
    end else begin : g_even
      assign cin[k] = sub;
    end
    assign t = {1'b0, a[k*SEG_W +: SEG_W]} + {1'b0, b_eff[k*SEG_W +: SEG_W]}
             + {{SEG_W{1'b0}}, cin[k]};
    assign sum[k*SEG_W +: SEG_W] = t[SEG_W-1:0];
    assign cout[k] = t[SEG_W];
  end
endmodule

// File: rtl/lane_cmp.sv
module lane_cmp
  import simd_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int SEG_W  = 16
) (
  input  logic [DATA_W-1:0]       a,
  input  logic [DATA_W-1:0]       b,
  input  logic                    wide,
  input  cmp_kind_e               kind,
  output logic [DATA_W/SEG_W-1:0] mask
);
  localparam int NSEG = DATA_W / SEG_W;
  localparam int NW   = NSEG / 2;
  localparam int WW   = 2 * SEG_W;

  logic [NSEG-1:0] gt_n, eq_n;
  logic [NW-1:0]   gt_w, eq_w;
  logic [NSEG-1:0] gt_s, eq_s;

  for (genvar k = 0; k < NSEG; k++) begin : g_n
    assign gt_n[k] = $signed(a[k*SEG_W +: SEG_W]) > $signed(b[k*SEG_W +: SEG_W]);
    assign eq_n[k] = a[k*SEG_W +: SEG_W] == b[k*SEG_W +: SEG_W];
  end

  for (genvar j = 0; j < NW; j++) begin : g_w
    assign gt_w[j] = $signed(a[j*WW +: WW]) > $signed(b[j*WW +: WW]);
    assign eq_w[j] = a[j*WW +: WW] == b[j*WW +: WW];
  end

  assign gt_s = wide ? {{(NSEG-NW){1'b0}}, gt_w} : gt_n;
  assign eq_s = wide ? {{(NSEG-NW){1'b0}}, eq_w} : eq_n;

  // inverted results must not light the unused upper lanes in wide mode
  logic [NSEG-1:0] live;
  assign live = wide ? {{(NSEG-NW){1'b0}}, {NW{1'b1}}} : {NSEG{1'b1}};

  always_comb begin
    unique case (kind)
      CMP_GT:  mask = gt_s;
      CMP_LE:  mask = ~gt_s & live;
      CMP_NE:  mask = ~eq_s & live;
      default: mask = eq_s;
    endcase
  end
endmodule

// File: rtl/bitwise_fn.sv
module bitwise_fn #(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [3:0]        code,
  output logic [DATA_W-1:0] y
);
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign y[i] = code[{a[i], b[i]}];
  end
endmodule

// File: rtl/simd_alu.sv
module simd_alu
  import simd_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int LANE_W = 16,
  localparam int NLANE = DATA_W / LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic [2:0]        opcode,
  input  logic              lane32,
  input  logic              narrow,
  input  logic [3:0]        lfunc,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic [NLANE-1:0]  cmp_mask
);
  localparam int HALF_W = DATA_W / 2;

  simd_op_e          op;
  cmp_kind_e         kind;
  logic [DATA_W-1:0] sum, logic_y, low_keep;
  logic [NLANE-1:0]  mask_c;
  logic [DATA_W-1:0] nxt_res;
  logic [NLANE-1:0]  nxt_mask;

  assign op       = simd_op_e'(opcode);
  assign low_keep = narrow ? {{HALF_W{1'b0}}, {HALF_W{1'b1}}} : {DATA_W{1'b1}};

  always_comb begin
    unique case (op)
      OP_CLE:  kind = CMP_LE;
      OP_CNE:  kind = CMP_NE;
      OP_CEQ:  kind = CMP_EQ;
      default: kind = CMP_GT;
    endcase
  end

  lane_addsub #(.DATA_W(DATA_W), .SEG_W(LANE_W)) u_add (
    .a(op_a), .b(op_b), .sub(op == OP_SUB), .wide(lane32), .sum(sum)
  );

  lane_cmp #(.DATA_W(DATA_W), .SEG_W(LANE_W)) u_cmp (
    .a(op_a), .b(op_b), .wide(lane32), .kind(kind), .mask(mask_c)
  );

  bitwise_fn #(.DATA_W(DATA_W)) u_log (
    .a(op_a), .b(op_b), .code(lfunc), .y(logic_y)
  );

  always_comb begin
    nxt_res  = '0;
    nxt_mask = '0;
    unique case (op)
      OP_ADD, OP_SUB: nxt_res = sum & low_keep;
      OP_CGT, OP_CLE, OP_CNE, OP_CEQ: begin
        nxt_mask = mask_c;
        nxt_res  = {{(DATA_W-NLANE){1'b0}}, mask_c};
      end
      OP_LOGIC: nxt_res = logic_y & low_keep;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      cmp_mask  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result   <= nxt_res;
        cmp_mask <= nxt_mask;
      end
    end
  end
endmodule

// File: rtl/simd_alu_chk.sv
module simd_alu_chk #(
  parameter int DATA_W = 64,
  parameter int LANE_W = 16,
  localparam int NLANE = DATA_W / LANE_W
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [2:0]        opcode,
  input logic              lane32,
  input logic              narrow,
  input logic              out_valid,
  input logic [DATA_W-1:0] result,
  input logic [NLANE-1:0]  cmp_mask
);
  localparam int HALF_W = DATA_W / 2;

  logic is_cmp;
  assign is_cmp = (opcode >= 3'd2) && (opcode <= 3'd5);

  p_valid_follow_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_valid_drop_r2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(result) && $stable(cmp_mask)));
  p_narrow_upper_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && narrow && (opcode <= 3'd1 || opcode == 3'd6))
      |=> (result[DATA_W-1:HALF_W] == '0));
  p_wide_mask_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && is_cmp && lane32) |=> (cmp_mask[NLANE-1:NLANE/2] == '0));
  p_noncmp_mask_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !is_cmp) |=> (cmp_mask == '0));
  p_cmp_on_result_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && is_cmp) |=> (result == {{(DATA_W-NLANE){1'b0}}, cmp_mask}));
  p_reserved_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && opcode == 3'd7) |=> (result == '0 && cmp_mask == '0));
endmodule

bind simd_alu simd_alu_chk #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .opcode(opcode),
  .lane32(lane32), .narrow(narrow), .out_valid(out_valid),
  .result(result), .cmp_mask(cmp_mask)
);

// File: tb/sim_simd_alu.sv
`timescale 1ns/1ps
module sim_simd_alu;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [63:0] op_a = '0, op_b = '0;
  logic [2:0]  opcode = '0;
  logic        lane32 = 1'b0, narrow = 1'b0;
  logic [3:0]  lfunc = '0;
  logic        out_valid;
  logic [63:0] result;
  logic [3:0]  cmp_mask;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [63:0] got_res;
  logic [3:0]  got_mask;
  logic        got_v;

  always #4 clk = ~clk;

  simd_alu u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .opcode(opcode), .lane32(lane32), .narrow(narrow), .lfunc(lfunc),
    .out_valid(out_valid), .result(result), .cmp_mask(cmp_mask)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // independent lane model: {mask, result}
  function automatic logic [67:0] model(input logic [2:0] op, input logic [63:0] a,
      input logic [63:0] b, input logic l32, input logic nr, input logic [3:0] fn);
    logic [63:0] r;
    logic [3:0]  m;
    logic        gt, eq, bit_r;
    r = '0;
    m = '0;
    case (op)
      3'd0, 3'd1: begin
        if (!l32) begin
          for (int i = 0; i < 4; i++)
            r[16*i +: 16] = (op == 3'd1) ? a[16*i +: 16] - b[16*i +: 16]
                                         : a[16*i +: 16] + b[16*i +: 16];
        end else begin
          for (int i = 0; i < 2; i++)
            r[32*i +: 32] = (op == 3'd1) ? a[32*i +: 32] - b[32*i +: 32]
                                         : a[32*i +: 32] + b[32*i +: 32];
        end
        if (nr) r[63:32] = '0;
      end
      3'd2, 3'd3, 3'd4, 3'd5: begin
        for (int i = 0; i < (l32 ? 2 : 4); i++) begin
          if (l32) begin
            gt = $signed(a[32*i +: 32]) > $signed(b[32*i +: 32]);
            eq = a[32*i +: 32] == b[32*i +: 32];
          end else begin
            gt = $signed(a[16*i +: 16]) > $signed(b[16*i +: 16]);
            eq = a[16*i +: 16] == b[16*i +: 16];
          end
          case (op)
            3'd2: bit_r = gt;
            3'd3: bit_r = !gt;
            3'd4: bit_r = !eq;
            default: bit_r = eq;
          endcase
          m[i] = bit_r;
        end
        r = {60'b0, m};
      end
      3'd6: begin
        r = ({64{fn[3]}} & a & b) | ({64{fn[2]}} & a & ~b)
          | ({64{fn[1]}} & ~a & b) | ({64{fn[0]}} & ~a & ~b);
        if (nr) r[63:32] = '0;
      end
      default: ;
    endcase
    return {m, r};
  endfunction

  task automatic run(input logic [2:0] op, input logic [63:0] a, input logic [63:0] b,
      input logic l32, input logic nr, input logic [3:0] fn);
    @(negedge clk);
    opcode = op; op_a = a; op_b = b; lane32 = l32; narrow = nr; lfunc = fn;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    got_res = result;
    got_mask = cmp_mask;
    got_v = out_valid;
  endtask

  task automatic run_model(input string req, input logic [2:0] op, input logic [63:0] a,
      input logic [63:0] b, input logic l32, input logic nr, input logic [3:0] fn);
    logic [67:0] e;
    e = model(op, a, b, l32, nr, fn);
    run(op, a, b, l32, nr, fn);
    chk(req, got_res, e[63:0]);
    chk(req, {60'b0, got_mask}, {60'b0, e[67:64]});
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk("R1 out_valid", {63'b0, out_valid}, 64'd0);
    chk("R1 result", result, 64'd0);
    chk("R1 cmp_mask", {60'b0, cmp_mask}, 64'd0);
    rst = 1'b0;
  endtask

  task automatic t_add_boundary;
    run(3'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0001_0001_0001_0001, 1'b0, 1'b0, 4'h0);
    chk("R3 all-ones plus one per 16-bit lane", got_res, 64'h0);
    chk("R2 out_valid after op", {63'b0, got_v}, 64'd1);
    run(3'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0001_0001_0001_0001, 1'b1, 1'b0, 4'h0);
    chk("R4 same pair in 32-bit lanes", got_res, 64'h0001_0000_0001_0000);
    run(3'd0, 64'h0000_FFFF_0000_FFFF, 64'h0000_0001_0000_0001, 1'b1, 1'b0, 4'h0);
    chk("R4 carry inside 32-bit lane", got_res, 64'h0001_0000_0001_0000);
    run(3'd0, 64'h0000_FFFF_0000_FFFF, 64'h0000_0001_0000_0001, 1'b0, 1'b0, 4'h0);
    chk("R3 no carry into lane 1", got_res, 64'h0);
    run(3'd0, 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0001, 1'b1, 1'b0, 4'h0);
    chk("R4 no carry across bit 32", got_res, 64'h0);
  endtask

  task automatic t_sub_wrap;
    run(3'd1, 64'h0, 64'h0001_0001_0001_0001, 1'b0, 1'b0, 4'h0);
    chk("R5 zero minus one per 16-bit lane", got_res, 64'hFFFF_FFFF_FFFF_FFFF);
    run(3'd1, 64'h0, 64'h0001_0001_0001_0001, 1'b1, 1'b0, 4'h0);
    chk("R5 zero minus pair in 32-bit lanes", got_res, 64'hFFFE_FFFF_FFFE_FFFF);
  endtask

  task automatic t_narrow;
    run(3'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1234_5678_0001_0002, 1'b0, 1'b1, 4'h0);
    chk("R6 narrow add 16-bit lanes", got_res, 64'h0000_0000_0000_0001);
    run(3'd0, 64'hAAAA_AAAA_0000_FFFF, 64'h5555_5555_0000_0001, 1'b1, 1'b1, 4'h0);
    chk("R6 narrow add one 32-bit lane", got_res, 64'h0000_0000_0001_0000);
    run(3'd6, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 1'b0, 1'b1, 4'b1111);
    chk("R6 narrow ones fill", got_res, 64'h0000_0000_FFFF_FFFF);
  endtask

  task automatic t_random_arith;
    for (int n = 0; n < 40; n++) begin
      logic [63:0] a, b;
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      run_model("R3 random add 16", 3'd0, a, b, 1'b0, 1'b0, 4'h0);
      run_model("R4 random add 32", 3'd0, a, b, 1'b1, 1'b0, 4'h0);
      run_model("R5 random sub", 3'd1, a, b, n[0], 1'b0, 4'h0);
      run_model("R6 random narrow", 3'd1, a, b, n[1], 1'b1, 4'h0);
    end
  endtask

  task automatic t_compare;
    logic [63:0] a, b;
    a = {16'h8000, 16'h7FFF, 16'h0005, 16'h0005};
    b = {16'h7FFF, 16'h8000, 16'h0005, 16'h0004};
    run(3'd2, a, b, 1'b0, 1'b0, 4'h0);
    chk("R7 gt 16-bit signed mask", {60'b0, got_mask}, 64'h5);
    chk("R8 gt mask on result", got_res, 64'h5);
    run(3'd3, a, b, 1'b0, 1'b0, 4'h0);
    chk("R7 le 16-bit mask", {60'b0, got_mask}, 64'hA);
    run(3'd4, a, b, 1'b0, 1'b1, 4'h0);
    chk("R7 ne mask, narrow has no effect", {60'b0, got_mask}, 64'hD);
    run(3'd5, a, b, 1'b0, 1'b0, 4'h0);
    chk("R7 eq 16-bit mask", {60'b0, got_mask}, 64'h2);
    run(3'd2, a, b, 1'b1, 1'b0, 4'h0);
    chk("R7 gt 32-bit signed mask", {60'b0, got_mask}, 64'h1);
    run(3'd3, a, b, 1'b1, 1'b0, 4'h0);
    chk("R7 le 32-bit mask upper bits zero", {60'b0, got_mask}, 64'h2);
    for (int n = 0; n < 24; n++) begin
      logic [63:0] x, y;
      x = {$urandom, $urandom};
      y = n[0] ? x ^ {32'h0, $urandom} : {$urandom, $urandom};
      run_model("R7 random compare", 3'(2 + (n % 4)), x, y, n[2], n[3], 4'h0);
    end
    run(3'd0, 64'h1, 64'h1, 1'b0, 1'b0, 4'h0);
    chk("R7 add leaves mask zero", {60'b0, got_mask}, 64'h0);
  endtask

  task automatic t_logic;
    logic [63:0] a, b;
    a = 64'hFF00_FF00_F0F0_1234;
    b = 64'hF0F0_0FF0_3C3C_ABCD;
    run(3'd6, a, b, 1'b0, 1'b0, 4'b1000);
    chk("R9 AND", got_res, a & b);
    run(3'd6, a, b, 1'b0, 1'b0, 4'b1110);
    chk("R9 OR", got_res, a | b);
    run(3'd6, a, b, 1'b0, 1'b0, 4'b0110);
    chk("R9 XOR", got_res, a ^ b);
    run(3'd6, a, b, 1'b0, 1'b0, 4'b1100);
    chk("R9 pass a", got_res, a);
    run(3'd6, a, b, 1'b0, 1'b0, 4'b1010);
    chk("R9 pass b", got_res, b);
    for (int f = 0; f < 16; f++) begin
      run_model("R9 all truth codes", 3'd6, a, b, 1'b0, 1'b0, 4'(f));
      run_model("R6 narrow truth codes", 3'd6, a, b, 1'b1, 1'b1, 4'(f));
    end
  endtask

  task automatic t_hold;
    logic [63:0] kept;
    run(3'd0, 64'h0000_0001_0002_0003, 64'h0000_0010_0020_0030, 1'b0, 1'b0, 4'h0);
    kept = got_res;
    chk("R3 simple lane add", kept, 64'h0000_0011_0022_0033);
    opcode = 3'd6; op_a = '1; op_b = '1; lfunc = 4'hF;
    repeat (3) @(negedge clk);
    chk("R2 result holds while idle", result, kept);
    chk("R2 out_valid low while idle", {63'b0, out_valid}, 64'd0);
  endtask

  task automatic t_reserved;
    run(3'd7, 64'hDEAD_BEEF_0123_4567, 64'h1111_2222_3333_4444, 1'b0, 1'b0, 4'hF);
    chk("R10 reserved result zero", got_res, 64'h0);
    chk("R10 reserved mask zero", {60'b0, got_mask}, 64'h0);
  endtask

  initial begin
    t_reset;
    t_add_boundary;
    t_sub_wrap;
    t_narrow;
    t_random_arith;
    t_compare;
    t_logic;
    t_hold;
    t_reserved;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule